// File: doc/BRIEF.md
# Interrupt Control and Status Unit

This unit keeps the interrupt state of a bus bridge in two 32-bit registers. The status register collects single-cycle event pulses from five sources. Each source has its own status bit, and that bit stays set until software clears it. The control register holds one enable per source. Its top bit is a software-owned soft-reset request, which the unit brings out on a dedicated output.

One level-sensitive interrupt line is asserted while any status bit is set whose enable is also set. Software clears status bits by writing a 1 to each bit it wants cleared. If an event arrives in the same cycle as a clear of its bit, the event wins.

A parameter selects between a host variant and a guest variant. The guest variant lacks the system-error and parity-error sources. Those positions read as zero and ignore both writes and events.

Top module: `irq_csr_unit`

## Requirements
- R1: After reset both registers read 0, and irq_o and soft_rst_o are 0.
- R2: A write with wr_sel_i=0 loads the control register from wr_data_i on the next clock edge. Bit 31 and the implemented enable bits 4..0 are stored, and every other bit reads 0.
- R3: soft_rst_o follows control bit 31. It changes on the same clock edge that stores a new value of bit 31.
- R4: An event pulse on evt_i[k] sets status bit k on the next edge. The bit stays set while no clear arrives. Bit mapping: 4 system error, 3 parity error, 2 first-bus error, 1 second-bus error, 0 general interrupt.
- R5: A write with wr_sel_i=1 clears every status bit where wr_data_i holds a 1. Bits where wr_data_i holds a 0 keep their value.
- R6: When an event on a bit and a clear of that same bit happen in the same cycle, the bit ends up set.
- R7: irq_o is 1 exactly when some status bit k and control bit k are both 1, for k in 0..4.
- R8: In the guest variant (HOST_VARIANT=0), bits 4 and 3 of both registers always read 0. Writes and events on those bits have no effect.
- R9: rd_data_o shows the control register when rd_sel_i=0 and the status register when rd_sel_i=1. Status bits 31..5 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 5 | Event pulses, one per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 control, 1 status |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 1 | Read target: 0 control, 1 status |
| rd_data_o | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Interrupt request |
| soft_rst_o | output | 1 | Soft-reset request |

## Verification
Writes and events both change state on the first clock edge after they are presented. The read data, irq_o and soft_rst_o are combinational from the registers, so all of them are due in the cycle that follows that edge. The bench drives inputs on the falling edge. It updates its reference model at the rising edge and samples every output shortly after that edge, toggling rd_sel_i to read both registers. A host instance and a guest instance share the same stimulus and are compared against separate models.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;
  localparam int unsigned NUM_SRC      = 5;
  localparam int unsigned HOST_ONLY_LO = 3;  // sources at or above this index exist only in host builds

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;

  function automatic logic [NUM_SRC-1:0] src_mask(input bit host);
    logic [NUM_SRC-1:0] m;
    for (int i = 0; i < NUM_SRC; i++) m[i] = host || (i < HOST_ONLY_LO);
    return m;
  endfunction
endpackage

// File: rtl/irq_csr_ctrl_reg.sv
module irq_csr_ctrl_reg #(
  parameter int unsigned     REG_W  = 32,
  parameter logic [REG_W-1:0] WMASK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] ctrl_o
);
  logic [REG_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (we_i) ctrl_q <= wdata_i & WMASK;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/irq_csr_stat_reg.sv
module irq_csr_stat_reg #(
  parameter int unsigned         N    = 5,
  parameter logic [N-1:0]        IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    if (IMPL[k]) begin : g_impl
      logic bit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       bit_q <= 1'b0;
        else if (evt_i[k]) bit_q <= 1'b1;  // event beats clear
        else if (clr_i[k]) bit_q <= 1'b0;
      end
      assign stat_o[k] = bit_q;
    end else begin : g_absent
      assign stat_o[k] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_csr_irq_gen.sv
module irq_csr_irq_gen #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] stat_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic [N-1:0] pend;
  for (genvar k = 0; k < N; k++) begin : g_pend
    assign pend[k] = stat_i[k] & en_i[k];
  end
  assign irq_o = |pend;
endmodule

// File: rtl/irq_csr_unit.sv
module irq_csr_unit
  import irq_csr_pkg::*;
#(
  parameter int unsigned REG_W        = 32,
  parameter bit          HOST_VARIANT = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  evt_i,
  input  logic                wr_en_i,
  input  logic                wr_sel_i,
  input  logic [REG_W-1:0]    wr_data_i,
  input  logic                rd_sel_i,
  output logic [REG_W-1:0]    rd_data_o,
  output logic                irq_o,
  output logic                soft_rst_o
);
  localparam int unsigned        SRST_BIT  = REG_W - 1;
  localparam logic [NUM_SRC-1:0] SRC_MASK  = src_mask(HOST_VARIANT);
  localparam logic [REG_W-1:0]   CTRL_MASK = {1'b1, {(REG_W-1){1'b0}}}
                                           | {{(REG_W-NUM_SRC){1'b0}}, SRC_MASK};

  logic [REG_W-1:0]   ctrl_q;
  logic [NUM_SRC-1:0] stat_q;
  logic [NUM_SRC-1:0] clr;
  logic               ctrl_we;

  assign ctrl_we = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_CTRL);
  assign clr     = (wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_STAT))
                 ? wr_data_i[NUM_SRC-1:0] : '0;

  irq_csr_ctrl_reg #(.REG_W(REG_W), .WMASK(CTRL_MASK)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ctrl_we),
    .wdata_i(wr_data_i),
    .ctrl_o (ctrl_q)
  );

  irq_csr_stat_reg #(.N(NUM_SRC), .IMPL(SRC_MASK)) u_stat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt_i),
    .clr_i (clr),
    .stat_o(stat_q)
  );

  irq_csr_irq_gen #(.N(NUM_SRC)) u_irq (
    .stat_i(stat_q),
    .en_i  (ctrl_q[NUM_SRC-1:0]),
    .irq_o (irq_o)
  );

  assign soft_rst_o = ctrl_q[SRST_BIT];
  assign rd_data_o  = (reg_sel_e'(rd_sel_i) == SEL_STAT)
                    ? {{(REG_W-NUM_SRC){1'b0}}, stat_q} : ctrl_q;
endmodule

// File: rtl/irq_csr_chk.sv
module irq_csr_chk
  import irq_csr_pkg::*;
#(
  parameter int unsigned REG_W        = 32,
  parameter bit          HOST_VARIANT = 1'b1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               wr_en_i,
  input logic               wr_sel_i,
  input logic [REG_W-1:0]   wr_data_i,
  input logic               rd_sel_i,
  input logic [REG_W-1:0]   rd_data_o,
  input logic               irq_o,
  input logic               soft_rst_o,
  input logic [NUM_SRC-1:0] stat_q
);
  localparam logic [NUM_SRC-1:0] SRC_MASK  = src_mask(HOST_VARIANT);
  localparam logic [REG_W-1:0]   CTRL_MASK = {1'b1, {(REG_W-1){1'b0}}}
                                           | {{(REG_W-NUM_SRC){1'b0}}, SRC_MASK};
  localparam logic [REG_W-1:0]   STAT_MASK = {{(REG_W-NUM_SRC){1'b0}}, SRC_MASK};

  a_r3_soft_rst_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i) |=> (soft_rst_o == $past(wr_data_i[REG_W-1])));

  // R6 is covered here as well: an event sets its bit even under a clear
  a_r4_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(evt_i & SRC_MASK)) |=> ((stat_q & $past(evt_i & SRC_MASK)) == $past(evt_i & SRC_MASK)));

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i == '0 && !(wr_en_i && wr_sel_i)) |=> $stable(stat_q));

  a_r5_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i && (|(wr_data_i[NUM_SRC-1:0] & ~evt_i)))
    |=> ((stat_q & $past(wr_data_i[NUM_SRC-1:0] & ~evt_i)) == '0));

  a_r7_enable_raises_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i && (|(wr_data_i[NUM_SRC-1:0] & stat_q & SRC_MASK))) |=> irq_o);

  a_r2_ctrl_unimpl_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_sel_i |-> ((rd_data_o & ~CTRL_MASK) == '0));

  a_r8_stat_unimpl_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sel_i |-> ((rd_data_o & ~STAT_MASK) == '0));
endmodule

bind irq_csr_unit irq_csr_chk #(.REG_W(REG_W), .HOST_VARIANT(HOST_VARIANT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .evt_i     (evt_i),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .rd_sel_i  (rd_sel_i),
  .rd_data_o (rd_data_o),
  .irq_o     (irq_o),
  .soft_rst_o(soft_rst_o),
  .stat_q    (stat_q)
);

// File: tb/irq_csr_unit_tb.sv
module irq_csr_unit_tb;
  localparam int CLK_P = 10;
  localparam logic [4:0] HOST_M  = 5'b11111;
  localparam logic [4:0] GUEST_M = 5'b00111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  evt = '0;
  logic        we = 1'b0, wsel = 1'b0, rsel = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_h, rd_g;
  logic        irq_h, irq_g, srst_h, srst_g;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] e_ctrl_h = '0, e_ctrl_g = '0;
  logic [4:0]  e_stat_h = '0, e_stat_g = '0;

  always #(CLK_P/2) clk = ~clk;

  irq_csr_unit #(.HOST_VARIANT(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .wr_en_i(we), .wr_sel_i(wsel),
    .wr_data_i(wdata), .rd_sel_i(rsel), .rd_data_o(rd_h), .irq_o(irq_h), .soft_rst_o(srst_h));

  irq_csr_unit #(.HOST_VARIANT(1'b0)) u_dut_guest (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .wr_en_i(we), .wr_sel_i(wsel),
    .wr_data_i(wdata), .rd_sel_i(rsel), .rd_data_o(rd_g), .irq_o(irq_g), .soft_rst_o(srst_g));

  function automatic logic [31:0] nxt_ctrl(logic [31:0] old, logic w, logic s, logic [31:0] d, logic [4:0] m);
    if (w && !s) return d & {1'b1, 26'b0, m};
    return old;
  endfunction

  function automatic logic [4:0] nxt_stat(logic [4:0] old, logic [4:0] e, logic w, logic s, logic [31:0] d, logic [4:0] m);
    logic [4:0] c;
    c = (w && s) ? d[4:0] : 5'b0;
    return ((old & ~c) | e) & m;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    rsel = 1'b0; #1;
    chk({tag, " R2 R9 host ctrl"}, rd_h, e_ctrl_h);
    chk({tag, " R8 guest ctrl"}, rd_g, e_ctrl_g);
    chk({tag, " R3 host srst"}, {31'b0, srst_h}, {31'b0, e_ctrl_h[31]});
    chk({tag, " R3 guest srst"}, {31'b0, srst_g}, {31'b0, e_ctrl_g[31]});
    chk({tag, " R7 host irq"}, {31'b0, irq_h}, {31'b0, |(e_stat_h & e_ctrl_h[4:0])});
    chk({tag, " R7 guest irq"}, {31'b0, irq_g}, {31'b0, |(e_stat_g & e_ctrl_g[4:0])});
    rsel = 1'b1; #1;
    chk({tag, " R4 R9 host stat"}, rd_h, {27'b0, e_stat_h});
    chk({tag, " R8 guest stat"}, rd_g, {27'b0, e_stat_g});
  endtask

  task automatic step(string tag, logic [4:0] e, logic w, logic s, logic [31:0] d);
    @(negedge clk);
    evt = e; we = w; wsel = s; wdata = d;
    @(posedge clk);
    e_ctrl_h = nxt_ctrl(e_ctrl_h, w, s, d, HOST_M);
    e_ctrl_g = nxt_ctrl(e_ctrl_g, w, s, d, GUEST_M);
    e_stat_h = nxt_stat(e_stat_h, e, w, s, d, HOST_M);
    e_stat_g = nxt_stat(e_stat_g, e, w, s, d, GUEST_M);
    #1;
    check_all(tag);
    @(negedge clk);
    evt = '0; we = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #(CLK_P*2 + 2);
    check_all("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check_all("R1 after reset");

    step("R2 ctrl all ones", 5'b0, 1'b1, 1'b0, 32'hFFFF_FFFF);
    step("R3 ctrl clear", 5'b0, 1'b1, 1'b0, 32'h0);
    step("R4 events no enable", 5'b11111, 1'b0, 1'b0, 32'h0);
    step("R4 hold", 5'b0, 1'b0, 1'b0, 32'h0);
    step("R7 enable bit3", 5'b0, 1'b1, 1'b0, 32'h0000_0008);
    step("R5 write zero no effect", 5'b0, 1'b1, 1'b1, 32'h0);
    step("R5 clear bit3", 5'b0, 1'b1, 1'b1, 32'h0000_0008);
    step("R6 event beats clear", 5'b00001, 1'b1, 1'b1, 32'h0000_0001);
    step("R8 guest high bits", 5'b11000, 1'b1, 1'b1, 32'h0000_0007);
    step("R5 clear all", 5'b0, 1'b1, 1'b1, 32'hFFFF_FFFF);
    step("R3 soft reset set", 5'b0, 1'b1, 1'b0, 32'h8000_0000);

    for (int i = 0; i < 400; i++) begin
      logic [4:0] e;
      e = ($urandom % 3 == 0) ? 5'($urandom) : 5'b0;
      step("random", e, 1'($urandom), 1'($urandom), $urandom);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule